// File: doc/BRIEF.md
# Serial receive frame queue

This block sits behind an asynchronous serial receiver. It collects received 9-bit frames into a 16-entry circular store, so that a processor can drain them in bursts of eight instead of servicing every frame. The receiver presents each frame with a one-cycle valid strobe, together with framing-error, parity-error and noise indications. It presents a separate idle-line strobe.

The store is split into a lower half (entries 0 to 7) and an upper half (entries 8 to 15). Each half has its own full flag and its own interrupt. Software drains one half while the receiver fills the other. A frame that arrives for a half that is still marked full is an overrun. An overrun, or a frame with a framing or parity error, halts the queue by dropping its enable bit. The offending frame is not written.

The processor side is a simple register port with a select, a write strobe, an address, write data and combinational read data.

- Addresses 0 to 15 return the stored frames in bits 8:0.
- Address 16 is the control register.
- Address 17 is the status register.

Top module: `rxq_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 (all flags clear, write index 0) and all three interrupt outputs are low.
- R2: Control bits are: bit 0 queue enable, bit 1 receiver enable, bit 2 lower-half interrupt enable, bit 3 upper-half interrupt enable, bit 4 idle interrupt enable. A clean frame accepted while the queue is open is written at the entry given by the 4-bit write index. The index then advances by one, wrapping from 15 to 0. The index is visible in status bits 11:8, and entry n reads back at address n in bits 8:0.
- R3: Status bit 3 is the framing error and status bit 4 is the parity error. An accepted-gate frame carrying either error is not written and leaves the index unchanged. It sets the matching error bit(s) and clears control bit 0.
- R4: Frames are ignored (no write, no index change, no flag change) unless queue enable and receiver enable are both set and the overrun, framing-error and parity-error bits are all clear.
- R5: Status bit 0 (lower half full) sets when entry 7 is written. Status bit 1 (upper half full) sets when entry 15 is written. irq_lo and irq_hi are high while the matching flag and its enable bit are both set.
- R6: Status bit 2 is the overrun flag. A clean frame whose target half (chosen by index bit 3) still has its full flag set is not written and leaves the index unchanged. It sets overrun and clears control bit 0.
- R7: A half-full flag clears only when a status read that saw it set is followed by a status write with that bit 0. A status write without such a read leaves it set.
- R8: Status bit 5 is the noise flag. A clean frame flagged with noise is still written and sets the noise flag.
- R9: Status bit 6 is the idle flag. It is set by the idle strobe while receiver enable is set, and drives irq_idle when control bit 4 is set.
- R10: The noise, idle, overrun, framing-error and parity-error flags each clear when a status read that saw the flag set is followed by a read of any queue entry.
- R11: Writing control bit 0 from 0 to 1 resets the write index to 0. A control write that leaves bit 0 at 1 keeps the index.
- R12: When hardware sets a flag in the same cycle that a clear sequence completes for it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_data | input | 9 | Received frame |
| rx_ferr | input | 1 | Framing error for this frame |
| rx_perr | input | 1 | Parity error for this frame |
| rx_noise | input | 1 | Noise detected during this frame |
| rx_idle | input | 1 | One-cycle strobe: idle line detected |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 5 | Register address (0-15 entries, 16 control, 17 status) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed register |
| irq_lo | output | 1 | Lower half full interrupt |
| irq_hi | output | 1 | Upper half full interrupt |
| irq_idle | output | 1 | Idle line interrupt |

## Verification
The assertions assume that the receiver never raises the frame strobe during reset. They also assume that the processor never writes the control register in the same cycle as a frame whose acceptance they check. This is because a queue re-enable may legitimately zero the index.

The directed tasks drive the receiver and the register port only on falling edges, and they never combine a control write with a frame. The single intentional collision, a queue read meeting a noisy frame, is confined to the status-flag path.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int ENTRIES_DEF = 16;
    localparam int FRAME_W_DEF = 9;
    localparam int BUS_W_DEF   = 16;

    typedef struct packed {
        logic idle_ie;
        logic hi_ie;
        logic lo_ie;
        logic ren;
        logic qen;
    } ctrl_t;

    typedef struct packed {
        logic idle;
        logic noise;
        logic perr;
        logic ferr;
        logic ovr;
        logic hi_full;
        logic lo_full;
    } flags_t;

    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int FLAGS_W = $bits(flags_t);

    function automatic flags_t no_flags();
        return '0;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int ENTRIES = rxq_pkg::ENTRIES_DEF,
    parameter int FRAME_W = rxq_pkg::FRAME_W_DEF,
    localparam int PW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [PW-1:0]      waddr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic [PW-1:0]      raddr,
    output logic [FRAME_W-1:0] rdata
);

    logic [FRAME_W-1:0] cells [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (we && waddr == PW'(g))
                cells[g] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
    import rxq_pkg::*;
#(
    parameter int ENTRIES = rxq_pkg::ENTRIES_DEF,
    localparam int PW = $clog2(ENTRIES)
) (
    input  ctrl_t         ctrl,
    input  flags_t        flags,
    input  logic [PW-1:0] ptr,
    input  logic          rx_valid,
    input  logic          rx_ferr,
    input  logic          rx_perr,
    input  logic          rx_noise,
    input  logic          rx_idle,
    output logic          store,
    output logic          halt,
    output flags_t        set
);

    localparam logic [PW-1:0] LO_LAST = PW'(ENTRIES / 2 - 1);
    localparam logic [PW-1:0] HI_LAST = PW'(ENTRIES - 1);

    logic open_q, take, bad, busy, ovrun;

    always_comb begin
        open_q = ctrl.qen && ctrl.ren && !flags.ovr && !flags.ferr && !flags.perr;
        take   = rx_valid && open_q;
        bad    = take && (rx_ferr || rx_perr);
        busy   = ptr[PW-1] ? flags.hi_full : flags.lo_full;
        ovrun  = take && !bad && busy;
        store  = take && !bad && !busy;
        halt   = bad || ovrun;

        set         = no_flags();
        set.lo_full = store && (ptr == LO_LAST);
        set.hi_full = store && (ptr == HI_LAST);
        set.ovr     = ovrun;
        set.ferr    = bad && rx_ferr;
        set.perr    = bad && rx_perr;
        set.noise   = store && rx_noise;
        set.idle    = rx_idle && ctrl.ren;
    end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int ENTRIES = rxq_pkg::ENTRIES_DEF,
    localparam int PW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  ctrl_t         wr_val,
    input  logic          halt,
    input  logic          store,
    output ctrl_t         ctrl,
    output logic [PW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= wr_val;
            if (halt)
                ctrl.qen <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (store)
            ptr <= ptr + 1'b1;
        else if (wr_ctrl && wr_val.qen && !ctrl.qen)
            ptr <= '0;
    end

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set,
    input  logic   stat_rd,
    input  logic   stat_wr,
    input  logic   wr_lo_zero,
    input  logic   wr_hi_zero,
    input  logic   q_rd,
    output flags_t flags
);

    flags_t armed, clr;

    always_comb begin
        clr         = no_flags();
        clr.lo_full = stat_wr && wr_lo_zero && armed.lo_full;
        clr.hi_full = stat_wr && wr_hi_zero && armed.hi_full;
        clr.ovr     = q_rd && armed.ovr;
        clr.ferr    = q_rd && armed.ferr;
        clr.perr    = q_rd && armed.perr;
        clr.noise   = q_rd && armed.noise;
        clr.idle    = q_rd && armed.idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
            if (stat_rd)
                armed <= flags;
            else
                armed <= armed & ~clr;
        end
    end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int ENTRIES = rxq_pkg::ENTRIES_DEF,
    parameter int FRAME_W = rxq_pkg::FRAME_W_DEF,
    parameter int BUS_W   = rxq_pkg::BUS_W_DEF,
    localparam int PW = $clog2(ENTRIES),
    localparam int AW = PW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [FRAME_W-1:0] rx_data,
    input  logic               rx_ferr,
    input  logic               rx_perr,
    input  logic               rx_noise,
    input  logic               rx_idle,
    input  logic               cpu_sel,
    input  logic               cpu_we,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [BUS_W-1:0]   cpu_wdata,
    output logic [BUS_W-1:0]   cpu_rdata,
    output logic               irq_lo,
    output logic               irq_hi,
    output logic               irq_idle
);

    localparam logic [AW-1:0] A_CTRL = AW'(ENTRIES);
    localparam logic [AW-1:0] A_STAT = AW'(ENTRIES + 1);

    ctrl_t              ctrl_q;
    flags_t             flags_q, flags_set;
    logic [PW-1:0]      ptr_q;
    logic               store, halt;
    logic [FRAME_W-1:0] entry;
    logic               is_q, is_ctrl, is_stat, rd, wr;

    always_comb begin
        is_q    = !cpu_addr[AW-1];
        is_ctrl = cpu_addr == A_CTRL;
        is_stat = cpu_addr == A_STAT;
        rd      = cpu_sel && !cpu_we;
        wr      = cpu_sel && cpu_we;
    end

    rxq_admit #(.ENTRIES(ENTRIES)) u_admit (
        .ctrl     (ctrl_q),
        .flags    (flags_q),
        .ptr      (ptr_q),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr),
        .rx_perr  (rx_perr),
        .rx_noise (rx_noise),
        .rx_idle  (rx_idle),
        .store    (store),
        .halt     (halt),
        .set      (flags_set)
    );

    rxq_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr && is_ctrl),
        .wr_val  (ctrl_t'(cpu_wdata[CTRL_W-1:0])),
        .halt    (halt),
        .store   (store),
        .ctrl    (ctrl_q),
        .ptr     (ptr_q)
    );

    rxq_status u_status (
        .clk        (clk),
        .rst        (rst),
        .set        (flags_set),
        .stat_rd    (rd && is_stat),
        .stat_wr    (wr && is_stat),
        .wr_lo_zero (!cpu_wdata[0]),
        .wr_hi_zero (!cpu_wdata[1]),
        .q_rd       (rd && is_q),
        .flags      (flags_q)
    );

    rxq_store #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store),
        .waddr (ptr_q),
        .wdata (rx_data),
        .raddr (cpu_addr[PW-1:0]),
        .rdata (entry)
    );

    always_comb begin
        if (is_q)
            cpu_rdata = BUS_W'(entry);
        else if (is_ctrl)
            cpu_rdata = BUS_W'(ctrl_q);
        else if (is_stat)
            cpu_rdata = BUS_W'({ptr_q, 1'b0, flags_q});
        else
            cpu_rdata = '0;
    end

    assign irq_lo   = flags_q.lo_full && ctrl_q.lo_ie;
    assign irq_hi   = flags_q.hi_full && ctrl_q.hi_ie;
    assign irq_idle = flags_q.idle && ctrl_q.idle_ie;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
    import rxq_pkg::*;
#(
    parameter int ENTRIES = rxq_pkg::ENTRIES_DEF,
    localparam int PW = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rx_ferr,
    input logic          rx_perr,
    input ctrl_t         ctrl,
    input flags_t        flags,
    input logic [PW-1:0] ptr,
    input logic          irq_lo
);

    logic gate_open, clean, half_busy;
    assign gate_open = ctrl.qen && ctrl.ren && !flags.ovr && !flags.ferr && !flags.perr;
    assign clean     = !rx_ferr && !rx_perr;
    assign half_busy = ptr[PW-1] ? flags.hi_full : flags.lo_full;

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0));

    a_r3_err_halts: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && gate_open && !clean) |=> (!ctrl.qen && (flags.ferr || flags.perr)));

    a_r3_err_no_store: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && gate_open && !clean) |=> $stable(ptr));

    a_r4_closed_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.qen) |=> ($stable(ptr) || ptr == '0));

    a_r6_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && gate_open && clean && half_busy) |=> (flags.ovr && !ctrl.qen && $stable(ptr)));

    a_r5_lo_full_set: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && gate_open && clean && !half_busy && ptr == PW'(ENTRIES / 2 - 1)) |=> flags.lo_full);

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> flags.lo_full);

endmodule

bind rxq_top rxq_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr),
    .rx_perr  (rx_perr),
    .ctrl     (ctrl_q),
    .flags    (flags_q),
    .ptr      (ptr_q),
    .irq_lo   (irq_lo)
);

// File: tb/rxq_top_bench.sv
`timescale 1ns/1ps
module rxq_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0, rx_noise = 1'b0, rx_idle = 1'b0;
    logic [8:0]  rx_data = '0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq_lo, irq_hi, irq_idle;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [8:0] model [16];
    int mptr = 0;

    always #2 clk = ~clk;

    rxq_top u_rxq_top (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [15:0] e, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v === e, req, v, e);
    endtask

    task automatic send(input logic [8:0] d, input bit fe, input bit pe, input bit nz, input bit kept);
        @(negedge clk);
        rx_valid = 1; rx_data = d; rx_ferr = fe; rx_perr = pe; rx_noise = nz;
        @(negedge clk);
        rx_valid = 0; rx_ferr = 0; rx_perr = 0; rx_noise = 0;
        if (kept) begin
            model[mptr] = d;
            mptr = (mptr + 1) % 16;
        end
    endtask

    task automatic t_reset();
        expect_reg(5'd16, 16'h0000, "R1 ctrl");
        expect_reg(5'd17, 16'h0000, "R1 status");
        check({irq_lo, irq_hi, irq_idle} == 3'b000, "R1 irqs", {irq_lo, irq_hi, irq_idle}, 0);
    endtask

    task automatic t_fill_lower();
        wr(5'd16, 16'h001F);
        for (int i = 0; i < 8; i++) send(9'(i * 37 + 5), 0, 0, 0, 1);
        check(irq_lo === 1'b1, "R5 irq_lo", irq_lo, 1);
        wr(5'd17, 16'h0000);
        check(irq_lo === 1'b1, "R7 write without read", irq_lo, 1);
        expect_reg(5'd17, 16'h0801, "R5 lower full, R2 index 8");
        wr(5'd17, 16'h0000);
        check(irq_lo === 1'b0, "R7 cleared irq", irq_lo, 0);
        expect_reg(5'd17, 16'h0800, "R7 cleared flag");
    endtask

    task automatic t_fill_upper_noise();
        for (int i = 0; i < 8; i++) send(9'(300 + i * 11), 0, 0, (i == 2), 1);
        check(irq_hi === 1'b1, "R5 irq_hi", irq_hi, 1);
        expect_reg(5'd17, 16'h0022, "R2 wrap, R5 upper full, R8 noise");
        expect_reg(5'd10, 16'(model[10]), "R8 noisy frame stored");
        expect_reg(5'd17, 16'h0002, "R10 noise cleared");
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 8; i++) send(9'(i * 53 + 2), 0, 0, 0, 1);
        expect_reg(5'd17, 16'h0803, "R5 both halves full");
        send(9'h1AA, 0, 0, 0, 0);
        expect_reg(5'd17, 16'h0807, "R6 overrun flag, index kept");
        expect_reg(5'd16, 16'h001E, "R6 queue enable dropped");
        send(9'h0AA, 0, 0, 0, 0);
        expect_reg(5'd17, 16'h0807, "R4 disabled queue ignores frame");
        wr(5'd16, 16'h001F);
        expect_reg(5'd17, 16'h0007, "R11 re-enable resets index");
        send(9'h055, 0, 0, 0, 0);
        expect_reg(5'd17, 16'h0007, "R4 overrun blocks frames");
        mptr = 0;
    endtask

    task automatic t_recover_gate();
        expect_reg(5'd0, 16'(model[0]), "R4 entry 0 untouched");
        expect_reg(5'd17, 16'h0003, "R10 overrun cleared");
        wr(5'd17, 16'h0000);
        expect_reg(5'd17, 16'h0000, "R7 both halves cleared");
        send(9'h123, 0, 0, 0, 1);
        expect_reg(5'd17, 16'h0100, "R2 store at 0");
        wr(5'd16, 16'h001D);
        send(9'h0F0, 0, 0, 0, 0);
        expect_reg(5'd17, 16'h0100, "R4 receiver disabled");
        wr(5'd16, 16'h001F);
        expect_reg(5'd17, 16'h0100, "R11 index kept when enable stays");
    endtask

    task automatic t_errors();
        send(9'h0E1, 1, 0, 0, 0);
        expect_reg(5'd17, 16'h0108, "R3 framing error");
        expect_reg(5'd16, 16'h001E, "R3 enable dropped");
        expect_reg(5'd1, 16'(model[1]), "R3 entry 1 not written");
        expect_reg(5'd17, 16'h0100, "R10 framing error cleared");
        wr(5'd16, 16'h001F);
        mptr = 0;
        send(9'h0E2, 0, 1, 0, 0);
        expect_reg(5'd17, 16'h0010, "R3 parity error, R11 index 0");
    endtask

    task automatic t_idle();
        @(negedge clk); rx_idle = 1;
        @(negedge clk); rx_idle = 0;
        check(irq_idle === 1'b1, "R9 irq_idle", irq_idle, 1);
        expect_reg(5'd17, 16'h0050, "R9 idle flag");
        expect_reg(5'd0, 16'(model[0]), "R3 entry 0 intact");
        expect_reg(5'd17, 16'h0000, "R10 idle and parity cleared");
        check(irq_idle === 1'b0, "R9 irq_idle low", irq_idle, 0);
    endtask

    task automatic t_set_wins();
        wr(5'd16, 16'h001F);
        send(9'h111, 0, 0, 1, 1);
        expect_reg(5'd17, 16'h0120, "R8 noise set");
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = 5'd0;
        rx_valid = 1; rx_data = 9'h122; rx_noise = 1;
        @(negedge clk);
        cpu_sel = 0; rx_valid = 0; rx_noise = 0;
        model[mptr] = 9'h122; mptr++;
        expect_reg(5'd17, 16'h0220, "R12 set beats clear");
        expect_reg(5'd1, 16'(model[1]), "R12 frame stored");
        expect_reg(5'd17, 16'h0200, "R10 noise cleared later");
    endtask

    task automatic t_entries();
        for (int i = 0; i < 16; i++) expect_reg(5'(i), 16'(model[i]), "R2 entry readback");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_fill_lower();
        t_fill_upper_noise();
        t_overrun();
        t_recover_gate();
        t_errors();
        t_idle();
        t_set_wins();
        t_entries();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule